// File: doc/BRIEF.md
# Serial Two-Wire Byte-Memory Target with Upper-Quarter Write Lock

This block is the bus side of a serial byte memory. It watches a two-wire I2C bus (clock and data), resamples both lines into the system clock domain, and answers as a target. A controller selects it with a device byte, then sends two word-address bytes. After that it either delivers one data byte, which is stored when the STOP arrives, or it issues a repeated START with the read bit and clocks out bytes from consecutive addresses. The data line is open-drain: the block only asserts a pull-low enable, and an external resistor supplies the high level.

The byte array itself lies outside the block. It is reached through a plain port: an address, write data, a one-cycle write strobe, and read data that follows the address without a register stage. A lock input guards the upper quarter of the address space. While the lock is high, bytes aimed at that quarter are still acknowledged on the bus, but the write strobe never fires for them. The address width is a parameter. At the default of 14 bits the guarded range is 3000h to 3FFFh.

Top module: `i2c_eeprom_target`

## Requirements
- R1: A START is SDA falling while SCL is high. Until the first START after reset, the block never pulls SDA low, whatever toggles on the bus.
- R2: The device byte is acknowledged only when its bits 7:4 are 1010. Bits 3:1 are don't-care and bit 0 selects the direction (0 write, 1 read). On a mismatch there is no acknowledge, and SDA stays released until the next START.
- R3: The word address is sent high byte first, then low byte. Only the low ADDR_W-8 bits of the high byte are used and the rest are ignored.
- R4: A write is committed only by a STOP. The commit is a single-cycle mem_we_o pulse in the cycle after the STOP is recognised, carrying the received address and data.
- R5: A START that arrives before the STOP discards the pending write byte, so no strobe is issued for it.
- R6: With wp_i high and the two address MSBs at 11 (3000h to 3FFFh at default width), every byte of the write is acknowledged, yet mem_we_o stays low.
- R7: With wp_i low, any address in the array, top quarter included, is written.
- R8: Random read: word address, then a repeated START with device byte bit 0 = 1, returns the byte at that address, MSB first.
- R9: Every controller ACK after a read byte yields the byte at the next address. The address wraps from the top address to 0.
- R10: A controller NACK ends the read. SDA stays released through any further SCL pulses until a new START.
- R11: A read with no word address starts at the internal pointer. After a read, the pointer is one past the last byte sent. After a write, it holds the written address.
- R12: A write carries one data byte only. A second data byte gets no acknowledge and is not stored.
- R13: SDA is only ever pulled low or released. The pull-low enable changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin (wired level) |
| wp_i | input | 1 | Upper-quarter write lock, active high; tie low when unused |
| sda_pull_o | output | 1 | Open-drain enable: 1 pulls SDA low |
| mem_addr_o | output | ADDR_W | Array address (current pointer) |
| mem_wdata_o | output | 8 | Byte to store |
| mem_we_o | output | 1 | Single-cycle store strobe |
| mem_rdata_i | input | 8 | Array byte at mem_addr_o, combinational |

## Verification
A corrupted bit counter or FSM state shows up on the bus within one byte. The acknowledge slot lands on the wrong clock pulse, or the returned byte is shifted, and both appear at the next ACK sample or the next compared read byte. A bad address pointer stays hidden until a later read returns a neighbour's byte, so every write in the sweep is read back at once, and a sequential read runs across the wrap point. A bad commit or lock decision is visible right after the STOP, as an unexpected or missing mem_we_o pulse, and a later readback confirms it.

// File: rtl/eeprom_i2c_pkg.sv
// Package: shared state encoding and constants for the two-wire memory target.
// Assumes: included first in compile order.
package eeprom_i2c_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEV,
        ST_DEV_ACK,
        ST_AHI,
        ST_AHI_ACK,
        ST_ALO,
        ST_ALO_ACK,
        ST_WDAT,
        ST_WDAT_ACK,
        ST_RDAT,
        ST_RACK,
        ST_SKIP
    } tgt_state_t;

    localparam logic [3:0] DEV_TYPE = 4'b1010;
    localparam int         BYTE_W   = 8;

endpackage

// File: rtl/i2c_line_sync.sv
// Module: i2c_line_sync
// Resamples SCL and SDA into the system clock through a STAGES-deep flop
// chain, then flags SCL edges and START/STOP conditions on the resampled
// values. Assumes: STAGES >= 2, the bus idles high, and both lines pass
// through equal-depth chains so their relative timing is preserved.
module i2c_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    logic [STAGES-1:0] scl_chain;
    logic [STAGES-1:0] sda_chain;
    logic              scl_q;
    logic              sda_q;

    // Shift the raw lines through the resampling chains (reset to idle-high).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_chain <= '1;
            sda_chain <= '1;
        end else begin
            scl_chain <= {scl_chain[STAGES-2:0], scl_i};
            sda_chain <= {sda_chain[STAGES-2:0], sda_i};
        end
    end

    assign scl_s = scl_chain[STAGES-1];
    assign sda_s = sda_chain[STAGES-1];

    // Keep the previous resampled values for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    // Decode edges and bus conditions from current and previous samples.
    always_comb begin
        scl_rise  = scl_s & ~scl_q;
        scl_fall  = ~scl_s & scl_q;
        start_det = scl_s & scl_q & sda_q & ~sda_s;
        stop_det  = scl_s & scl_q & ~sda_q & sda_s;
    end

endmodule

// File: rtl/wp_write_guard.sv
// Module: wp_write_guard
// Decides whether a store is blocked: the lock input is high and every
// one of the REGION_W top address bits is set (the upper 1/2^REGION_W of
// the array). Assumes: REGION_W >= 1 and the caller passes the address MSBs.
module wp_write_guard #(
    parameter int REGION_W = 2
) (
    input  logic                wp,
    input  logic [REGION_W-1:0] region,
    output logic                blocked
);

    // Block only inside the top region while the lock is high.
    always_comb begin
        blocked = wp & (&region);
    end

endmodule

// File: rtl/i2c_eeprom_target.sv
// Module: i2c_eeprom_target
// Two-wire bus target in front of an external byte array. Takes a device
// byte, a two-byte word address, then one data byte (stored on STOP) or a
// stream of read bytes from an auto-incrementing pointer. SDA is driven as
// a pull-low enable only. Assumes: mem_rdata_i follows mem_addr_o without a
// register stage; SCL low and high phases each last several system clocks;
// 9 <= ADDR_W <= 16.
module i2c_eeprom_target
    import eeprom_i2c_pkg::*;
#(
    parameter int ADDR_W      = 14,
    parameter int SYNC_STAGES = 2,
    parameter int LOCK_BITS   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic              wp_i,
    output logic              sda_pull_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [7:0]        mem_wdata_o,
    output logic              mem_we_o,
    input  logic [7:0]        mem_rdata_i
);

    localparam int HI_W  = ADDR_W - BYTE_W;
    localparam int CNT_W = $clog2(BYTE_W + 1);
    localparam logic [CNT_W-1:0] LAST_RX  = CNT_W'(BYTE_W);
    localparam logic [CNT_W-1:0] LAST_TX  = CNT_W'(BYTE_W - 1);

    tgt_state_t        state;
    logic [7:0]        shreg;
    logic [CNT_W-1:0]  bitcnt;
    logic [HI_W-1:0]   addr_hi;
    logic [ADDR_W-1:0] ptr;
    logic [7:0]        wbuf;
    logic              pend;
    logic              rw;
    logic              mack;
    logic              blocked;

    logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;

    i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    wp_write_guard #(.REGION_W(LOCK_BITS)) u_guard (
        .wp      (wp_i),
        .region  (ptr[ADDR_W-1 -: LOCK_BITS]),
        .blocked (blocked)
    );

    // Protocol sequencer: bus conditions first, then per-state bit handling.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            shreg    <= '0;
            bitcnt   <= '0;
            addr_hi  <= '0;
            ptr      <= '0;
            wbuf     <= '0;
            pend     <= 1'b0;
            rw       <= 1'b0;
            mack     <= 1'b0;
            mem_we_o <= 1'b0;
        end else begin
            mem_we_o <= 1'b0;
            if (stop_det) begin
                state    <= ST_IDLE;
                mem_we_o <= pend & ~blocked;
                pend     <= 1'b0;
            end else if (start_det) begin
                state  <= ST_DEV;
                bitcnt <= '0;
                pend   <= 1'b0;
            end else begin
                case (state)
                    ST_DEV, ST_AHI, ST_ALO, ST_WDAT: begin
                        if (scl_rise) begin
                            shreg  <= {shreg[6:0], sda_s};
                            bitcnt <= bitcnt + 1'b1;
                        end else if (scl_fall && bitcnt == LAST_RX) begin
                            bitcnt <= '0;
                            case (state)
                                ST_DEV: begin
                                    if (shreg[7:4] == DEV_TYPE) begin
                                        rw    <= shreg[0];
                                        state <= ST_DEV_ACK;
                                    end else begin
                                        state <= ST_SKIP;
                                    end
                                end
                                ST_AHI: begin
                                    addr_hi <= shreg[HI_W-1:0];
                                    state   <= ST_AHI_ACK;
                                end
                                ST_ALO: begin
                                    ptr   <= {addr_hi, shreg};
                                    state <= ST_ALO_ACK;
                                end
                                default: begin
                                    wbuf  <= shreg;
                                    pend  <= 1'b1;
                                    state <= ST_WDAT_ACK;
                                end
                            endcase
                        end
                    end
                    ST_DEV_ACK: begin
                        if (scl_fall) begin
                            if (rw) begin
                                shreg  <= mem_rdata_i;
                                bitcnt <= '0;
                                state  <= ST_RDAT;
                            end else begin
                                state <= ST_AHI;
                            end
                        end
                    end
                    ST_AHI_ACK:  if (scl_fall) state <= ST_ALO;
                    ST_ALO_ACK:  if (scl_fall) state <= ST_WDAT;
                    ST_WDAT_ACK: if (scl_fall) state <= ST_SKIP;
                    ST_RDAT: begin
                        if (scl_fall) begin
                            if (bitcnt == LAST_TX) begin
                                ptr   <= ptr + 1'b1;
                                state <= ST_RACK;
                            end else begin
                                shreg  <= {shreg[6:0], 1'b0};
                                bitcnt <= bitcnt + 1'b1;
                            end
                        end
                    end
                    ST_RACK: begin
                        if (scl_rise) begin
                            mack <= ~sda_s;
                        end else if (scl_fall) begin
                            if (mack) begin
                                shreg  <= mem_rdata_i;
                                bitcnt <= '0;
                                state  <= ST_RDAT;
                            end else begin
                                state <= ST_SKIP;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // Open-drain enable: acknowledge slots and zero bits of outgoing data.
    always_comb begin
        case (state)
            ST_DEV_ACK, ST_AHI_ACK, ST_ALO_ACK, ST_WDAT_ACK: sda_pull_o = 1'b1;
            ST_RDAT: sda_pull_o = ~shreg[7];
            default: sda_pull_o = 1'b0;
        endcase
    end

    assign mem_addr_o  = ptr;
    assign mem_wdata_o = wbuf;

    // R4
    commit_after_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we_o |-> $past(stop_det));

    // R4
    single_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we_o |=> !mem_we_o);

    // R6
    locked_region_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we_o |-> !(wp_i && (&mem_addr_o[ADDR_W-1 -: LOCK_BITS])));

    // R1
    idle_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> !sda_pull_o);

    // R13
    pull_moves_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_pull_o != $past(sda_pull_o)) |-> !$past(scl_s));

endmodule

// File: tb/i2c_eeprom_target_test.sv
// Bench: drives the bus as a controller, models the array, and compares
// every acknowledge and returned byte against values it computes itself.
module i2c_eeprom_target_test;

    localparam int AW    = 10;
    localparam int DEPTH = 1 << AW;
    localparam int HP    = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          scl = 1'b1;
    logic          sda_m = 1'b1;
    logic          wp = 1'b0;
    logic          sda_pull;
    logic          sda_bus;
    logic [AW-1:0] mem_addr;
    logic [7:0]    mem_wdata;
    logic          mem_we;
    logic [7:0]    mem_rdata;

    logic [7:0] mem [0:DEPTH-1];
    logic [7:0] expm [0:DEPTH-1];
    int checks = 0;
    int fails = 0;
    int we_count = 0;
    int r13_viol = 0;
    bit done = 0;

    always #10 clk = ~clk;

    assign sda_bus   = sda_m & ~sda_pull;
    assign mem_rdata = mem[mem_addr];

    i2c_eeprom_target #(.ADDR_W(AW)) uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .scl_i       (scl),
        .sda_i       (sda_bus),
        .wp_i        (wp),
        .sda_pull_o  (sda_pull),
        .mem_addr_o  (mem_addr),
        .mem_wdata_o (mem_wdata),
        .mem_we_o    (mem_we),
        .mem_rdata_i (mem_rdata)
    );

    // Array model: preset pattern in reset, store on strobe.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= 8'(i * 13 + 5);
        end else if (mem_we) begin
            mem[mem_addr] <= mem_wdata;
            we_count <= we_count + 1;
        end
    end

    // R13 monitor: pull enable must hold steady while SCL stays high.
    logic scl_prev = 1'b1;
    logic pull_prev = 1'b0;
    always @(negedge clk) begin
        if (rst_n && scl && scl_prev && (sda_pull !== pull_prev)) r13_viol++;
        scl_prev  <= scl;
        pull_prev <= sda_pull;
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clk_bit(input bit v, output bit s);
        wait_n(3);
        sda_m = v;
        wait_n(HP - 3);
        scl = 1'b1;
        wait_n(HP / 2);
        s = sda_bus;
        wait_n(HP / 2);
        scl = 1'b0;
    endtask

    task automatic bus_start();
        sda_m = 1'b1;
        wait_n(HP);
        scl = 1'b1;
        wait_n(HP);
        sda_m = 1'b0;
        wait_n(HP);
        scl = 1'b0;
        wait_n(HP);
    endtask

    task automatic bus_stop();
        wait_n(3);
        sda_m = 1'b0;
        wait_n(HP);
        scl = 1'b1;
        wait_n(HP);
        sda_m = 1'b1;
        wait_n(2 * HP);
    endtask

    task automatic send_byte(input logic [7:0] b, output bit acked);
        bit s;
        for (int i = 7; i >= 0; i--) clk_bit(b[i], s);
        clk_bit(1'b1, s);
        acked = !s;
    endtask

    task automatic recv_byte(input bit ack, output logic [7:0] b);
        bit s;
        for (int i = 0; i < 8; i++) begin
            clk_bit(1'b1, s);
            b = {b[6:0], s};
        end
        clk_bit(!ack, s);
    endtask

    function automatic logic [7:0] hi_byte(input int a);
        return {6'b101101, 2'(a >> 8)};
    endfunction

    task automatic send_addr(input int a, output bit ok);
        bit k;
        bus_start();
        send_byte(8'hA0, k); ok = k;
        send_byte(hi_byte(a), k); ok = ok & k;
        send_byte(8'(a), k); ok = ok & k;
    endtask

    task automatic wr_txn(input int a, input int d, output bit ok);
        bit k;
        send_addr(a, ok);
        send_byte(8'(d), k); ok = ok & k;
        bus_stop();
    endtask

    task automatic rd1(input int a, output logic [7:0] v);
        bit k;
        send_addr(a, k);
        bus_start();
        send_byte(8'hA1, k);
        recv_byte(1'b0, v);
        bus_stop();
    endtask

    task automatic run_all();
        bit ok, k, s;
        int w0, a, d;
        logic [7:0] v;

        // R1 / R13: reset state
        wait_n(5);
        chk("R1 reset pull", sda_pull, 0);
        chk("R4 reset strobe", mem_we, 0);
        rst_n = 1'b1;
        wait_n(4);

        // R1: a byte clocked with no START gets no acknowledge
        scl = 1'b0;
        for (int i = 7; i >= 0; i--) clk_bit(i == 7 || i == 5, s);
        clk_bit(1'b1, s);
        chk("R1 no ack before START", s, 1);
        sda_m = 1'b1;
        wait_n(HP);
        scl = 1'b1;
        wait_n(2 * HP);

        // R2: wrong type code is ignored, rest of frame silent
        bus_start();
        send_byte(8'hB0, k);
        chk("R2 mismatch nack", k, 0);
        send_byte(8'h00, k);
        chk("R2 silent after mismatch", k, 0);
        bus_stop();
        // R2: bits 3:1 are don't-care
        bus_start();
        send_byte(8'hAE, k);
        chk("R2 match with select bits set", k, 1);
        bus_stop();

        // R3 R6 R7 R8: sweep quarters, lock levels and offsets
        for (int q = 0; q < 4; q++) begin
            for (int w = 0; w < 2; w++) begin
                for (int j = 0; j < 3; j++) begin
                    a = q * 256 + j * 97 + w * 11 + 1;
                    d = (a * 3 + w * 64 + 33) & 255;
                    wp = w[0];
                    w0 = we_count;
                    wr_txn(a, d, ok);
                    chk((w == 1 && q == 3) ? "R6 locked write acked" : "R7 write acked", ok, 1);
                    chk((w == 1 && q == 3) ? "R6 no strobe" : "R4 one strobe",
                        we_count - w0, (w == 1 && q == 3) ? 0 : 1);
                    if (!(w == 1 && q == 3)) expm[a] = 8'(d);
                    else expm[a] = 8'(a * 13 + 5);
                    rd1(a, v);
                    chk("R8 R3 readback", v, expm[a]);
                end
            end
        end
        wp = 1'b0;
        for (int i = 0; i < DEPTH; i++) expm[i] = mem[i];

        // R4: nothing stored before the STOP
        w0 = we_count;
        send_addr(40, ok);
        send_byte(8'h3C, k);
        wait_n(4 * HP);
        chk("R4 no strobe before STOP", we_count - w0, 0);
        bus_stop();
        chk("R4 strobe after STOP", we_count - w0, 1);
        expm[40] = 8'h3C;
        rd1(40, v);
        chk("R4 stored byte", v, 8'h3C);

        // R5: repeated START drops the pending byte; R11 pointer holds address
        w0 = we_count;
        send_addr(77, ok);
        send_byte(8'hE7, k);
        bus_start();
        send_byte(8'hA1, k);
        recv_byte(1'b0, v);
        bus_stop();
        chk("R5 no strobe after restart", we_count - w0, 0);
        chk("R5 R11 byte unchanged", v, expm[77]);

        // R12: second data byte refused
        w0 = we_count;
        send_addr(500, ok);
        send_byte(8'h11, k);
        chk("R12 first data acked", k, 1);
        send_byte(8'h22, k);
        chk("R12 second data nacked", k, 0);
        bus_stop();
        chk("R12 one strobe", we_count - w0, 1);
        expm[500] = 8'h11;
        rd1(500, v);
        chk("R12 first byte kept", v, 8'h11);

        // R9: sequential read across the wrap; R10 silence after NACK
        send_addr(DEPTH - 2, ok);
        bus_start();
        send_byte(8'hA1, k);
        for (int i = 0; i < 4; i++) begin
            recv_byte(i != 3, v);
            chk("R9 sequential byte", v, expm[(DEPTH - 2 + i) % DEPTH]);
        end
        k = 1'b0;
        for (int i = 0; i < 9; i++) begin
            clk_bit(1'b1, s);
            if (!s) k = 1'b1;
        end
        chk("R10 released after NACK", k, 0);
        bus_stop();

        // R11: current-address read continues one past last byte sent
        bus_start();
        send_byte(8'hA1, k);
        recv_byte(1'b0, v);
        bus_stop();
        chk("R11 current address read", v, expm[2]);

        chk("R13 pull steady while SCL high", r13_viol, 0);
    endtask

    initial begin
        fork
            begin
                run_all();
                done = 1;
            end
            begin
                for (int c = 0; c < 190000 && !done; c++) @(posedge clk);
                if (!done) begin
                    fails++;
                    checks++;
                    $display("FAIL watchdog: actual timeout expected completion");
                end
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule